// File: doc/BRIEF.md
# Configurable-Sense Interrupt Request Latch

This block sits between a bank of raw interrupt lines and an interrupt arbiter. For every source it keeps a pending flag, a stored copy of the line's previous sample and a two-bit sense mode. Each clock it compares the current sample with the stored one and decides, according to the source's mode, whether the flag is raised, held, cleared or simply follows the line. The supported modes are level, falling edge, rising edge and any edge.

Toward the arbiter it emits one-cycle pulses. A raise pulse marks a request attempt for a source. A withdraw pulse marks a level source whose line has dropped while the arbiter reports that source as the one currently outstanding. Software can clear a flag by index, and so can the acknowledge path. Both clears act only on edge-mode sources. The sense mode of any source can be rewritten through a simple write port. Arbitration between sources is not part of this block.

Top module: `irq_sense_latch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pend`, `raise` and `withdraw` are all zero and every previous-sample bit is zero. After reset, each source whose bit is set in `LEVEL_INIT` is in level mode and every other source is in rising-edge mode. The mode encoding is 0 = level, 1 = falling edge, 2 = rising edge, 3 = any edge.
- R2: For a source in level mode (0), `pend[i]` after a clock edge equals the value `irq_in[i]` had at that edge. Software clear and acknowledge have no effect on it.
- R3: For a source in falling-edge mode (1), a sample of 0 whose previous sample was 1 sets `pend[i]` at that edge.
- R4: For a source in rising-edge mode (2), a sample of 1 whose previous sample was 0 sets `pend[i]` at that edge.
- R5: For a source in any-edge mode (3), a sample that differs from the previous sample sets `pend[i]` at that edge.
- R6: The previous sample of every source is updated at every clock edge, whatever its mode. A change of mode therefore never turns an older transition into an edge.
- R7: In an edge mode, `pend[i]` stays set until a software clear (`swclr_we` with `swclr_idx` = i) or an acknowledge (`ack_we` with `ack_idx` = i) removes it at the next edge.
- R8: When a clear and a qualifying edge hit the same source at the same clock edge, the edge wins and `pend[i]` stays 1.
- R9: `raise[i]` pulses for one cycle, at the same time as `pend[i]` is set. In an edge mode it pulses on every qualifying edge. In level mode it pulses when the flag goes from 0 to 1.
- R10: `withdraw[i]` pulses for one cycle after an edge at which source i was in level mode, had `pend[i]` = 1, sampled `irq_in[i]` = 0 and was reported outstanding (`busy_valid` with `busy_idx` = i).
- R11: A mode write (`cfg_we`, `cfg_idx`, `cfg_mode`) takes effect for the evaluation at the following clock edge. The evaluation at the write's own edge uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Raw interrupt lines, synchronous to `clk` |
| cfg_we | input | 1 | Sense-mode write strobe |
| cfg_idx | input | IDX_W | Source whose mode is written |
| cfg_mode | input | 2 | New sense mode (0 level, 1 falling, 2 rising, 3 any) |
| swclr_we | input | 1 | Software flag-clear strobe |
| swclr_idx | input | IDX_W | Source cleared by software |
| ack_we | input | 1 | Acknowledge-clear strobe |
| ack_idx | input | IDX_W | Source being acknowledged |
| busy_valid | input | 1 | Arbiter has an outstanding request |
| busy_idx | input | IDX_W | Index of the outstanding source |
| pend | output | N_SRC | Pending flags, registered |
| raise | output | N_SRC | One-cycle request-attempt pulses, registered |
| withdraw | output | N_SRC | One-cycle withdrawal pulses, registered |

## Verification
Every output is a single register stage behind its inputs. A line sample, a clear or an outstanding report presented before clock edge k is therefore visible on `pend`, `raise` and `withdraw` after edge k. A mode write at edge k first governs the evaluation at edge k+1. The bench drives stimulus on the falling edge and advances its behavioural model on the rising edge, using the same sampled inputs. It compares all three output vectors on the next falling edge, so each result is checked in the cycle it is due. Directed phases cover each mode and the clear races before a long biased-random run.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'd0,
    SENSE_FALL  = 2'd1,
    SENSE_RISE  = 2'd2,
    SENSE_ANY   = 2'd3
  } sense_e;
endpackage

// File: rtl/irq_sense_cfg.sv
module irq_sense_cfg #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] LEVEL_INIT = '0,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IDX_W-1:0]            idx,
  input  logic [1:0]                  mode_in,
  output irq_sense_pkg::sense_e [N_SRC-1:0] mode_q
);
  import irq_sense_pkg::*;

  for (genvar g = 0; g < N_SRC; g++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst)
        mode_q[g] <= LEVEL_INIT[g] ? SENSE_LEVEL : SENSE_RISE;
      else if (we && (int'(idx) == g))
        mode_q[g] <= sense_e'(mode_in);
    end
  end
endmodule

// File: rtl/irq_sense_slice.sv
module irq_sense_slice (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line,
  input  irq_sense_pkg::sense_e mode,
  input  logic                  clr,
  input  logic                  busy_me,
  output logic                  prev_q,
  output logic                  pend_q,
  output logic                  raise_q,
  output logic                  withdraw_q
);
  import irq_sense_pkg::*;

  logic rose, fell, edge_hit, is_level;

  always_comb begin
    rose     = line & ~prev_q;
    fell     = ~line & prev_q;
    is_level = (mode == SENSE_LEVEL);
    unique case (mode)
      SENSE_FALL: edge_hit = fell;
      SENSE_RISE: edge_hit = rose;
      SENSE_ANY:  edge_hit = rose | fell;
      default:    edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= 1'b0;
      pend_q     <= 1'b0;
      raise_q    <= 1'b0;
      withdraw_q <= 1'b0;
    end else begin
      prev_q <= line;
      if (is_level) begin
        pend_q     <= line;
        raise_q    <= line & ~pend_q;
        withdraw_q <= ~line & pend_q & busy_me;
      end else begin
        pend_q     <= edge_hit | (pend_q & ~clr);
        raise_q    <= edge_hit;
        withdraw_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_sense_latch.sv
module irq_sense_latch #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] LEVEL_INIT = 8'b0000_0101,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_mode,
  input  logic             swclr_we,
  input  logic [IDX_W-1:0] swclr_idx,
  input  logic             ack_we,
  input  logic [IDX_W-1:0] ack_idx,
  input  logic             busy_valid,
  input  logic [IDX_W-1:0] busy_idx,
  output logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] raise,
  output logic [N_SRC-1:0] withdraw
);
  import irq_sense_pkg::*;

  sense_e [N_SRC-1:0] mode_q;
  logic   [N_SRC-1:0] prev_vec;
  logic   [N_SRC-1:0] clr_vec;
  logic   [N_SRC-1:0] busy_vec;

  irq_sense_cfg #(.N_SRC(N_SRC), .LEVEL_INIT(LEVEL_INIT)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .idx    (cfg_idx),
    .mode_in(cfg_mode),
    .mode_q (mode_q)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_comb begin
      clr_vec[g]  = (swclr_we && (int'(swclr_idx) == g)) ||
                    (ack_we && (int'(ack_idx) == g));
      busy_vec[g] = busy_valid && (int'(busy_idx) == g);
    end

    irq_sense_slice u_slice (
      .clk       (clk),
      .rst       (rst),
      .line      (irq_in[g]),
      .mode      (mode_q[g]),
      .clr       (clr_vec[g]),
      .busy_me   (busy_vec[g]),
      .prev_q    (prev_vec[g]),
      .pend_q    (pend[g]),
      .raise_q   (raise[g]),
      .withdraw_q(withdraw[g])
    );
  end
endmodule

// File: rtl/irq_sense_latch_chk.sv
module irq_sense_latch_chk #(
  parameter int N_SRC = 8
) (
  input logic                               clk,
  input logic                               rst,
  input logic [N_SRC-1:0]                   irq_in,
  input irq_sense_pkg::sense_e [N_SRC-1:0]  mode_q,
  input logic [N_SRC-1:0]                   prev_vec,
  input logic [N_SRC-1:0]                   clr_vec,
  input logic [N_SRC-1:0]                   busy_vec,
  input logic [N_SRC-1:0]                   pend,
  input logic [N_SRC-1:0]                   raise,
  input logic [N_SRC-1:0]                   withdraw
);
  import irq_sense_pkg::*;

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] == SENSE_LEVEL) |=> (pend[g] == $past(irq_in[g])));

    assert_fall_sets_R3: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] == SENSE_FALL && !irq_in[g] && prev_vec[g]) |=> pend[g]);

    assert_rise_sets_R4: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] == SENSE_RISE && irq_in[g] && !prev_vec[g]) |=> pend[g]);

    assert_any_sets_R5: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] == SENSE_ANY && (irq_in[g] != prev_vec[g])) |=> pend[g]);

    assert_prev_tracks_R6: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (prev_vec[g] == $past(irq_in[g])));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] != SENSE_LEVEL && pend[g] && !clr_vec[g]) |=> pend[g]);

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] != SENSE_LEVEL && clr_vec[g] && (irq_in[g] == prev_vec[g]))
      |=> !pend[g]);

    assert_raise_with_pend_R9: assert property (@(posedge clk) disable iff (rst)
      raise[g] |-> pend[g]);

    assert_withdraw_R10: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] == SENSE_LEVEL && pend[g] && !irq_in[g] && busy_vec[g])
      |=> withdraw[g]);

    assert_withdraw_only_level_R10: assert property (@(posedge clk) disable iff (rst)
      (mode_q[g] != SENSE_LEVEL) |=> !withdraw[g]);
  end
endmodule

bind irq_sense_latch irq_sense_latch_chk #(.N_SRC(N_SRC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_in  (irq_in),
  .mode_q  (mode_q),
  .prev_vec(prev_vec),
  .clr_vec (clr_vec),
  .busy_vec(busy_vec),
  .pend    (pend),
  .raise   (raise),
  .withdraw(withdraw)
);

// File: tb/test_irq_sense_latch.sv
module test_irq_sense_latch;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;
  localparam logic [N-1:0] LVL_INIT = 8'b0000_0101;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  irq_in;
  logic          cfg_we, swclr_we, ack_we, busy_valid;
  logic [IW-1:0] cfg_idx, swclr_idx, ack_idx, busy_idx;
  logic [1:0]    cfg_mode;
  logic [N-1:0]  pend, raise, withdraw;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";

  int m_mode [N];
  int m_prev [N];
  int m_pend [N];
  logic [N-1:0] exp_pend, exp_raise, exp_wd;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sense_latch #(.N_SRC(N), .LEVEL_INIT(LVL_INIT)) i_irq_sense_latch (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode),
    .swclr_we(swclr_we), .swclr_idx(swclr_idx),
    .ack_we(ack_we), .ack_idx(ack_idx),
    .busy_valid(busy_valid), .busy_idx(busy_idx),
    .pend(pend), .raise(raise), .withdraw(withdraw)
  );

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_mode[i] = LVL_INIT[i] ? 0 : 2;
        m_prev[i] = 0;
        m_pend[i] = 0;
      end
      exp_raise = '0;
      exp_wd = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        int  x;
        bit  hit, clr, busy;
        x    = irq_in[i];
        clr  = (swclr_we && swclr_idx == i) || (ack_we && ack_idx == i);
        busy = busy_valid && busy_idx == i;
        exp_wd[i] = 1'b0;
        if (m_mode[i] == 0) begin
          exp_raise[i] = (x == 1 && m_pend[i] == 0);
          exp_wd[i]    = (x == 0 && m_pend[i] == 1 && busy);
          m_pend[i]    = x;
        end else begin
          hit = (m_mode[i] == 1 && m_prev[i] == 1 && x == 0) ||
                (m_mode[i] == 2 && m_prev[i] == 0 && x == 1) ||
                (m_mode[i] == 3 && m_prev[i] != x);
          exp_raise[i] = hit;
          if (hit) m_pend[i] = 1;
          else if (clr) m_pend[i] = 0;
        end
        m_prev[i] = x;
      end
      if (cfg_we) m_mode[cfg_idx] = cfg_mode;
    end
    for (int i = 0; i < N; i++) exp_pend[i] = (m_pend[i] != 0);
  end

  task automatic compare();
    vectors++;
    if (pend !== exp_pend) begin
      miscompares++;
      $display("FAIL %s pend: actual %b expected %b at %0t", phase, pend, exp_pend, $time);
    end
    if (raise !== exp_raise) begin
      miscompares++;
      $display("FAIL %s raise (R9): actual %b expected %b at %0t", phase, raise, exp_raise, $time);
    end
    if (withdraw !== exp_wd) begin
      miscompares++;
      $display("FAIL %s withdraw (R10): actual %b expected %b at %0t", phase, withdraw, exp_wd, $time);
    end
  endtask

  task automatic idle();
    cfg_we = 0; swclr_we = 0; ack_we = 0; busy_valid = 0;
    cfg_idx = '0; swclr_idx = '0; ack_idx = '0; busy_idx = '0; cfg_mode = '0;
  endtask

  // Wait one cycle, check outputs, leave inputs idle except the lines
  task automatic step();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic set_mode(input int idx, input int md);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_mode = 2'(md);
    step();
  endtask

  initial begin
    idle();
    irq_in = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    phase = "R1";
    compare();
    if (pend !== '0 || raise !== '0 || withdraw !== '0) begin
      miscompares++;
      $display("FAIL R1 reset outputs: actual %b/%b/%b expected zero", pend, raise, withdraw);
    end
    rst = 1'b0;
    step();

    // R1 defaults: src0 level, src1 rising
    phase = "R1 R2 R4";
    irq_in = 8'b0000_0011; step(); step();
    irq_in = 8'b0000_0000; step(); step();
    // R2: level ignores software clear and ack
    phase = "R2";
    irq_in[0] = 1; step();
    swclr_we = 1; swclr_idx = 0; ack_we = 1; ack_idx = 0; step();
    // R10: withdraw when level source drops while outstanding
    phase = "R10";
    irq_in[0] = 0; busy_valid = 1; busy_idx = 0; step(); step();
    // R7: clear edge source 1
    phase = "R7";
    swclr_we = 1; swclr_idx = 1; step();
    irq_in[1] = 1; step(); step();
    ack_we = 1; ack_idx = 1; step(); step();
    // R3 falling on source 3
    phase = "R3";
    set_mode(3, 1);
    irq_in[3] = 1; step(); step();
    irq_in[3] = 0; step(); step();
    // R5 any edge on source 4
    phase = "R5";
    set_mode(4, 3);
    irq_in[4] = 1; step();
    swclr_we = 1; swclr_idx = 4; step();
    irq_in[4] = 0; step(); step();
    // R8: clear and edge together on source 4
    phase = "R8";
    irq_in[4] = 1; swclr_we = 1; swclr_idx = 4; step(); step();
    // R6: line rises in falling mode, then switch to rising: no edge
    phase = "R6";
    set_mode(5, 1);
    irq_in[5] = 1; step();
    set_mode(5, 2); step(); step();
    // R11: mode write edge uses old mode
    phase = "R11";
    irq_in[6] = 1; cfg_we = 1; cfg_idx = 6; cfg_mode = 0; step();
    irq_in[6] = 0; step(); step();

    // Biased random run
    phase = "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11";
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 3) == 0) irq_in[i] = ~irq_in[i];
      if ($urandom_range(0, 9) == 0) begin
        cfg_we = 1; cfg_idx = IW'($urandom); cfg_mode = 2'($urandom);
      end
      swclr_we = ($urandom_range(0, 2) == 0); swclr_idx = IW'($urandom);
      ack_we = ($urandom_range(0, 2) == 0);   ack_idx = IW'($urandom);
      busy_valid = ($urandom_range(0, 1) == 0); busy_idx = IW'($urandom);
      @(negedge clk);
      compare();
      idle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule